// File: doc/BRIEF.md
# DRAM Strobe Sequencer with Refresh Row Extension

This block connects an 8-bit processor bus that has separate memory-request and refresh strobes to an array of 64K x 1 dynamic RAM devices. A single active-low memory request is turned into three staggered pulses: first the row strobe, then the select of the address multiplexer, then the column strobe. Each stage trails the one before it by exactly one clock. The DRAM pins receive the low address byte as the row and the high address byte as the column. Both address halves are held in a register, so the pins never see a half-switched value.

Refresh works differently. The processor counts only seven refresh address bits, but a 64K x 1 device needs eight row bits to refresh all 256 rows. The block therefore keeps its own eighth bit and flips it each time the seven-bit count passes its last value. In a refresh cycle only the row strobe pulses. The write strobe sent to the DRAM is registered from the processor's write strobe, so it is settled before the column strobe falls. All strobes return to inactive at the first clock edge that samples the request released.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `ras_n`=1, `cas_n`=1, `we_n`=1, `mux_sel`=0 and `dram_addr`=0, and the refresh extension bit is cleared to 0.
- R2: The edge that first samples `mreq_n` low drives `ras_n` low after it. On that same edge `dram_addr` loads the row address, which in a normal cycle is `addr[7:0]`.
- R3: In a normal cycle (`rfsh_n` high), if the request is still held at the next edge, `mux_sel` goes high after that edge. On the same edge `dram_addr` loads the column address `addr[15:8]`.
- R4: In a normal cycle, `cas_n` goes low one edge after `mux_sel` rises, provided the request is still held.
- R5: A cycle that starts with `rfsh_n` low is a refresh cycle. In it only `ras_n` pulses: `mux_sel` stays 0, and `cas_n` and `we_n` stay 1 even if `wr_n` is low.
- R6: In a refresh cycle, the row loaded into `dram_addr` is {extension bit, `addr[6:0]`}. `addr[7]` is ignored, and the extension bit is 0 after reset.
- R7: The extension bit inverts at the start of every refresh cycle whose `addr[6:0]` is 127. The following refresh cycles therefore use the other half of the 256 rows.
- R8: In a normal cycle, `we_n` is low after every edge that samples `wr_n` low while the request is held. A write asserted together with the request therefore has `we_n` low before `cas_n` falls.
- R9: After any edge that samples `mreq_n` high, `ras_n`, `cas_n` and `we_n` are 1 and `mux_sel` is 0. A new request after one idle clock starts a fresh sequence.
- R10: While `cas_n` stays low, `dram_addr` does not change. Between cycles it holds the last address it loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs are registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mreq_n | input | 1 | Processor memory request, active low |
| rfsh_n | input | 1 | Processor refresh indicator, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| addr | input | 16 | Processor address bus (refresh count on bits 6:0 during refresh) |
| dram_addr | output | 8 | Multiplexed row/column address to the DRAM devices |
| ras_n | output | 1 | Row address strobe, active low |
| mux_sel | output | 1 | Address multiplexer select, 1 = column half |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | DRAM write enable, active low |

## Verification
If the stage chain has the wrong state, the strobe timing is off by a clock at the ports within the first three clocks of a cycle: the column strobe falls too early or too late, or appears in a refresh cycle. A wrong extension bit changes only bit 7 of the refresh row, and it shows only on refreshes. A bit that never flips is therefore exposed only after the seven-bit count has wrapped, which takes 128 refreshes. The bench runs two full wraps for this reason. A wrong address register shows up as a changing or mis-selected `dram_addr` in the clock where the row or column is loaded, or while the column strobe is low.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  // Kind of cycle currently being served
  typedef enum logic [1:0] {
    CYC_IDLE    = 2'd0,
    CYC_ACCESS  = 2'd1,
    CYC_REFRESH = 2'd2
  } cyc_kind_t;

  // Stage indices inside the strobe chain
  localparam int unsigned STG_ROW = 0;
  localparam int unsigned STG_SEL = 1;
  localparam int unsigned STG_COL = 2;
  localparam int unsigned STG_NUM = 3;
endpackage

// File: rtl/dram_stage_chain.sv
// Clocked delay chain: stage 0 follows the request, each later stage
// follows the previous one by a clock, gated by the advance enable.
module dram_stage_chain #(
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             advance,
  output logic [DEPTH-1:0] stage
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
    end else begin
      stage[0] <= req;
      for (int i = 1; i < int'(DEPTH); i++) begin
        stage[i] <= req & advance & stage[i-1];
      end
    end
  end
endmodule

// File: rtl/dram_rfsh_ext.sv
// Extra top row bit for refresh: flips when the processor count wraps.
module dram_rfsh_ext #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rfsh_start,
  input  logic [CNT_W-1:0] rfsh_cnt,
  output logic             ext_bit
);
  logic at_last;
  assign at_last = &rfsh_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_bit <= 1'b0;
    end else if (rfsh_start && at_last) begin
      ext_bit <= ~ext_bit;
    end
  end
endmodule

// File: rtl/dram_addr_mux.sv
// Registered 2-to-1 row/column selection onto the DRAM address pins.
module dram_addr_mux #(
  parameter int unsigned ROW_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_row,
  input  logic               load_col,
  input  logic               refresh,
  input  logic               ext_bit,
  input  logic [2*ROW_W-1:0] addr,
  output logic [ROW_W-1:0]   dram_addr
);
  localparam int unsigned ADDR_W = 2 * ROW_W;
  localparam int unsigned CNT_W  = ROW_W - 1;

  logic [ROW_W-1:0] row_addr;
  logic [ROW_W-1:0] col_addr;

  always_comb begin
    if (refresh) row_addr = {ext_bit, addr[CNT_W-1:0]};
    else         row_addr = addr[ROW_W-1:0];
    col_addr = addr[ADDR_W-1:ROW_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dram_addr <= '0;
    end else if (load_row) begin
      dram_addr <= row_addr;
    end else if (load_col) begin
      dram_addr <= col_addr;
    end
  end
endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int unsigned ROW_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mreq_n,
  input  logic               rfsh_n,
  input  logic               wr_n,
  input  logic [2*ROW_W-1:0] addr,
  output logic [ROW_W-1:0]   dram_addr,
  output logic               ras_n,
  output logic               mux_sel,
  output logic               cas_n,
  output logic               we_n
);
  localparam int unsigned CNT_W = ROW_W - 1;

  logic               req;
  logic               start;
  logic               advance;
  logic               load_col;
  logic               rfsh_ext;
  logic               we_q;
  logic [STG_NUM-1:0] stage;
  cyc_kind_t          cyc_q;

  assign req     = ~mreq_n;
  assign start   = req & ~stage[STG_ROW];
  assign advance = rfsh_n & (cyc_q != CYC_REFRESH);
  assign load_col = req & advance & stage[STG_ROW] & ~stage[STG_SEL];

  dram_stage_chain #(.DEPTH(STG_NUM)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .advance (advance),
    .stage   (stage)
  );

  dram_rfsh_ext #(.CNT_W(CNT_W)) u_ext (
    .clk        (clk),
    .rst        (rst),
    .rfsh_start (start & ~rfsh_n),
    .rfsh_cnt   (addr[CNT_W-1:0]),
    .ext_bit    (rfsh_ext)
  );

  dram_addr_mux #(.ROW_W(ROW_W)) u_mux (
    .clk       (clk),
    .rst       (rst),
    .load_row  (start),
    .load_col  (load_col),
    .refresh   (~rfsh_n),
    .ext_bit   (rfsh_ext),
    .addr      (addr),
    .dram_addr (dram_addr)
  );

  always_ff @(posedge clk) begin
    if (rst || !req) begin
      cyc_q <= CYC_IDLE;
    end else if (start) begin
      cyc_q <= rfsh_n ? CYC_ACCESS : CYC_REFRESH;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) we_q <= 1'b0;
    else     we_q <= req & ~wr_n & rfsh_n & (start | (cyc_q == CYC_ACCESS));
  end

  assign ras_n   = ~stage[STG_ROW];
  assign mux_sel = stage[STG_SEL];
  assign cas_n   = ~stage[STG_COL];
  assign we_n    = ~we_q;
endmodule

// File: rtl/dram_strobe_ctrl_chk.sv
module dram_strobe_ctrl_chk #(
  parameter int unsigned ROW_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               mreq_n,
  input logic               rfsh_n,
  input logic               wr_n,
  input logic [2*ROW_W-1:0] addr,
  input logic [ROW_W-1:0]   dram_addr,
  input logic               ras_n,
  input logic               mux_sel,
  input logic               cas_n,
  input logic               we_n,
  input logic               rfsh_ext
);
  localparam int unsigned CNT_W = ROW_W - 1;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (ras_n && cas_n && we_n && !mux_sel && dram_addr == '0 && !rfsh_ext));

  a_r2_row_strobe: assert property (@(posedge clk) disable iff (rst)
    !mreq_n |=> !ras_n);

  a_r3_col_on_select: assert property (@(posedge clk) disable iff (rst)
    $rose(mux_sel) |-> dram_addr == $past(addr[2*ROW_W-1:ROW_W]));

  a_r4_col_strobe: assert property (@(posedge clk) disable iff (rst)
    (mux_sel && !mreq_n) |=> !cas_n);

  a_r4_col_inside_row: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> (!ras_n && mux_sel));

  a_r5_refresh_row_only: assert property (@(posedge clk) disable iff (rst)
    (!mreq_n && !rfsh_n && ras_n) |=> (cas_n && !mux_sel && we_n));

  a_r6_refresh_low_bits: assert property (@(posedge clk) disable iff (rst)
    (!mreq_n && !rfsh_n && ras_n) |=> dram_addr[CNT_W-1:0] == $past(addr[CNT_W-1:0]));

  a_r7_ext_flip: assert property (@(posedge clk) disable iff (rst)
    (!mreq_n && !rfsh_n && ras_n && (&addr[CNT_W-1:0])) |=> rfsh_ext != $past(rfsh_ext));

  a_r7_ext_hold: assert property (@(posedge clk) disable iff (rst)
    !(!mreq_n && !rfsh_n && ras_n && (&addr[CNT_W-1:0])) |=> $stable(rfsh_ext));

  a_r8_write_strobe: assert property (@(posedge clk) disable iff (rst)
    (!mreq_n && !wr_n && rfsh_n && ras_n) |=> !we_n);

  a_r9_release: assert property (@(posedge clk) disable iff (rst)
    mreq_n |=> (ras_n && cas_n && we_n && !mux_sel));

  a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!cas_n && $past(!cas_n)) |-> $stable(dram_addr));
endmodule

bind dram_strobe_ctrl dram_strobe_ctrl_chk #(.ROW_W(ROW_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mreq_n    (mreq_n),
  .rfsh_n    (rfsh_n),
  .wr_n      (wr_n),
  .addr      (addr),
  .dram_addr (dram_addr),
  .ras_n     (ras_n),
  .mux_sel   (mux_sel),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .rfsh_ext  (rfsh_ext)
);

// File: tb/dram_strobe_ctrl_test.sv
module dram_strobe_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mreq_n = 1'b1;
  logic        rfsh_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  dram_addr;
  logic        ras_n, mux_sel, cas_n, we_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_strobe_ctrl uut (
    .clk(clk), .rst(rst), .mreq_n(mreq_n), .rfsh_n(rfsh_n), .wr_n(wr_n),
    .addr(addr), .dram_addr(dram_addr), .ras_n(ras_n), .mux_sel(mux_sel),
    .cas_n(cas_n), .we_n(we_n)
  );

  typedef struct {
    logic       ras_n;
    logic       mux_sel;
    logic       cas_n;
    logic       we_n;
    logic [7:0] dram_addr;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  logic ext_model = 1'b0;
  logic [7:0] held_addr = 8'h00;

  // Drive one clock of inputs and queue what must appear after the next edge
  task automatic step(input logic m, input logic r, input logic w, input logic [15:0] a,
                      input logic e_ras, input logic e_mux, input logic e_cas,
                      input logic e_we, input logic [7:0] e_addr, input string tag);
    exp_t e;
    @(negedge clk);
    mreq_n = m; rfsh_n = r; wr_n = w; addr = a;
    e.ras_n = e_ras; e.mux_sel = e_mux; e.cas_n = e_cas; e.we_n = e_we;
    e.dram_addr = e_addr; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle_step(input string tag);
    step(1'b1, 1'b1, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, held_addr, tag);
  endtask

  task automatic mem_cycle(input logic [15:0] a, input logic write, input int nact);
    for (int i = 1; i <= nact; i++) begin
      logic [7:0] ea;
      string t;
      ea = (i >= 2) ? a[15:8] : a[7:0];
      if (i == 1)      t = "R2 row strobe and row address";
      else if (i == 2) t = "R3 select and column address";
      else             t = "R4 column strobe, R10 address held";
      if (write) t = {"R8 write, ", t};
      step(1'b0, 1'b1, ~write, a, 1'b0, (i >= 2), !(i >= 3), ~write, ea, t);
    end
    held_addr = (nact >= 2) ? a[15:8] : a[7:0];
    idle_step("R9 release after access");
  endtask

  task automatic refresh_cycle(input logic [6:0] cnt, input logic wr_low);
    logic [7:0] row;
    string t;
    row = {ext_model, cnt};
    t = ext_model ? "R7 refresh with flipped top bit" : "R6 refresh row";
    if (wr_low) t = {"R5 write ignored, ", t};
    for (int i = 1; i <= 2; i++) begin
      step(1'b0, 1'b0, ~wr_low, {8'h5A, 1'b1, cnt}, 1'b0, 1'b0, 1'b1, 1'b1, row, t);
    end
    held_addr = row;
    idle_step("R9 release after refresh");
    if (cnt == 7'h7F) ext_model = ~ext_model;
  endtask

  // Monitor: compares one queued item per clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      n_checks++;
      if (ras_n !== e.ras_n || mux_sel !== e.mux_sel || cas_n !== e.cas_n ||
          we_n !== e.we_n || dram_addr !== e.dram_addr) begin
        n_fail++;
        $display("FAIL %s: got ras_n=%b mux=%b cas_n=%b we_n=%b addr=%h, expected ras_n=%b mux=%b cas_n=%b we_n=%b addr=%h",
                 e.tag, ras_n, mux_sel, cas_n, we_n, dram_addr,
                 e.ras_n, e.mux_sel, e.cas_n, e.we_n, e.dram_addr);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R1: reset state, with a request held to show reset wins
    mreq_n = 1'b0; wr_n = 1'b0; addr = 16'hFFFF;
    repeat (3) @(posedge clk);
    #2;
    n_checks++;
    if (!(ras_n === 1'b1 && cas_n === 1'b1 && we_n === 1'b1 && mux_sel === 1'b0 && dram_addr === 8'h00)) begin
      n_fail++;
      $display("FAIL R1 reset: got ras_n=%b mux=%b cas_n=%b we_n=%b addr=%h, expected 1 0 1 1 00",
               ras_n, mux_sel, cas_n, we_n, dram_addr);
    end
    @(negedge clk);
    rst = 1'b0; mreq_n = 1'b1; wr_n = 1'b1; addr = '0;

    idle_step("R9 idle after reset");
    mem_cycle(16'h12C4, 1'b0, 4);
    mem_cycle(16'hAB80, 1'b1, 3);
    mem_cycle(16'h7F3E, 1'b0, 6);
    refresh_cycle(7'h05, 1'b0);
    refresh_cycle(7'h06, 1'b1);
    mem_cycle(16'h0155, 1'b1, 5);
    // short requests: released before the column stage
    mem_cycle(16'hC3E1, 1'b0, 1);
    mem_cycle(16'h9966, 1'b0, 2);
    // two full wraps of the processor refresh count
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 128; c++) begin
        refresh_cycle(7'(c), 1'b0);
        if (c == 64) mem_cycle(16'hE7A9, 1'b0, 3);
      end
    end
    refresh_cycle(7'h7F, 1'b0);
    refresh_cycle(7'h00, 1'b0);
    mem_cycle(16'h55AA, 1'b1, 4);

    while (sb.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule